// File: doc/BRIEF.md
# Multi-Module Memory Bank with Request and Return Queues

This block is one memory bank built from `N_MOD` independent storage modules that share a single request path and a single return path. Each clock cycle the requester may offer one request: a read or a write, an address and a tag. The low `log2(N_MOD)` bits of the address select a module. The rest of the address selects a word inside that module. The request is placed in that module's input queue. If that queue is full, the requester is stalled and must hold the request until it is taken.

Each module serves its queue in order. A module stays occupied for `CYCLE` cycles per request. Read data becomes available `ACCESS` cycles after the request starts, where `ACCESS` is less than `CYCLE`. Read results wait in a small per-module return queue. A round-robin arbiter moves at most one result per cycle onto the shared return bus, together with the tag of the request. Writes return nothing. Because modules work in parallel, results for different modules may come back in a different order from the one in which they were issued.

Top module: `bank_array`

## Requirements
- R1: A request is taken at a rising clock edge when `req_valid` and `req_ready` are both high. Module index = `req_addr[MOD_W-1:0]`. Word index = `req_addr[ADDR_W-1:MOD_W]`. `req_write` = 1 means write and 0 means read.
- R2: `req_ready` is low exactly when the addressed module's input queue (default depth 8) is full. A held request is taken at the first edge after a slot frees. With defaults, nine back-to-back writes to one idle module are all taken without stall, and a tenth write to that module waits 5 cycles.
- R3: A read to an idle module whose queues are empty gives `rsp_valid` high with its data and tag in the cycle after the edge that comes `ACCESS+2` (default 10) edges after the accepting edge.
- R4: Two successive starts in one module are at least `CYCLE` (default 12) cycles apart. Back-to-back reads to one idle module return 10 and 22 cycles after the first acceptance.
- R5: A write stores its data and gives no response. A later read of that word returns the data and the tag of the read.
- R6: Results from different modules may return out of issue order. For example, a read to a module that is still busy with a write returns after a later read to an idle module.
- R7: At most one result appears per cycle. Results that complete in the same cycle leave on consecutive cycles under round-robin arbitration, and none is lost.
- R8: A module starts a read only when its return queue has a free slot, so neither queue overflows.
- R9: After reset, `rsp_valid` is low and `req_ready` is high for every module.
- R10: Requests to one module take effect in acceptance order. A read after two writes to the same word returns the later data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Module index in low bits, word index above |
| req_wdata | input | DATA_W | Write data |
| req_tag | input | TAG_W | Tag returned with read data |
| req_ready | output | 1 | Addressed module's input queue has room |
| rsp_valid | output | 1 | Return bus carries a result |
| rsp_data | output | DATA_W | Read data |
| rsp_tag | output | TAG_W | Tag of the read |

## Verification
The bench counts every return cycle from the accepting edge. For an idle module, the path is one edge to start the request, `ACCESS` edges to the return queue, and one edge through the arbiter to the registered output: 10 cycles with the defaults. A second request to the same module adds the 12-cycle occupancy, so its result is due at 22. When two modules complete in the same cycle, their results are due on two consecutive cycles. Inputs are driven and outputs are sampled on the falling edge, so each result is checked in exactly the cycle it is due, and no edge race can shift it. The stall test counts falling edges with `req_ready` low and compares the count with the 5 cycles that the queue depth and cycle time give.

// File: rtl/bank_pkg.sv
package bank_pkg;

  typedef enum logic {OP_READ = 1'b0, OP_WRITE = 1'b1} op_e;

  // round-robin choice: first set bit after position 'last', wrapping; n if none
  function automatic int unsigned rr_next(logic [63:0] req, int unsigned last, int unsigned n);
    for (int unsigned i = 1; i <= n; i++) begin
      if (req[(last + i) % n]) return (last + i) % n;
    end
    return n;
  endfunction

endpackage

// File: rtl/bank_fifo.sv
module bank_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

endmodule

// File: rtl/bank_module.sv
module bank_module #(
  parameter int WORD_W   = 4,
  parameter int DATA_W   = 16,
  parameter int TAG_W    = 6,
  parameter int CYCLE    = 12,
  parameter int ACCESS   = 8,
  parameter int IQ_DEPTH = 8,
  parameter int OQ_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_push,
  input  logic              in_write,
  input  logic [WORD_W-1:0] in_waddr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [TAG_W-1:0]  in_tag,
  output logic              in_full,
  input  logic              out_pop,
  output logic [DATA_W-1:0] out_data,
  output logic [TAG_W-1:0]  out_tag,
  output logic              out_empty,
  output logic              out_full,
  output logic              started,
  output logic              finished
);
  localparam int IQ_W  = 1 + WORD_W + DATA_W + TAG_W;
  localparam int OQ_W  = DATA_W + TAG_W;
  localparam int WORDS = 1 << WORD_W;
  localparam int PH_W  = $clog2(CYCLE + 1);

  logic [IQ_W-1:0]   iq_rdata;
  logic              iq_empty;
  logic              hd_write;
  logic [WORD_W-1:0] hd_waddr;
  logic [DATA_W-1:0] hd_wdata;
  logic [TAG_W-1:0]  hd_tag;
  logic [PH_W-1:0]   phase;
  logic              cur_read;
  logic [WORD_W-1:0] cur_waddr;
  logic [TAG_W-1:0]  cur_tag;
  logic              free;
  logic [DATA_W-1:0] store [WORDS];
  logic [OQ_W-1:0]   oq_rdata;

  bank_fifo #(.W(IQ_W), .DEPTH(IQ_DEPTH)) u_iq (
    .clk(clk), .rst_n(rst_n),
    .push(in_push), .wdata({in_write, in_waddr, in_wdata, in_tag}),
    .pop(started), .rdata(iq_rdata), .full(in_full), .empty(iq_empty)
  );

  assign hd_write = iq_rdata[IQ_W-1];
  assign hd_waddr = iq_rdata[IQ_W-2 -: WORD_W];
  assign hd_wdata = iq_rdata[TAG_W +: DATA_W];
  assign hd_tag   = iq_rdata[TAG_W-1:0];

  // module is free when idle or its occupancy period has run out
  assign free     = (phase == '0) || (phase == PH_W'(CYCLE));
  assign started  = free && !iq_empty && (hd_write || !out_full);
  assign finished = cur_read && (phase == PH_W'(ACCESS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= '0;
      cur_read <= 1'b0;
    end else if (started) begin
      phase    <= PH_W'(1);
      cur_read <= !hd_write;
    end else if (phase == PH_W'(CYCLE)) begin
      phase    <= '0;
    end else if (phase != '0) begin
      phase    <= phase + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (started) begin
      cur_waddr <= hd_waddr;
      cur_tag   <= hd_tag;
    end
    if (started && hd_write) store[hd_waddr] <= hd_wdata;
  end

  bank_fifo #(.W(OQ_W), .DEPTH(OQ_DEPTH)) u_oq (
    .clk(clk), .rst_n(rst_n),
    .push(finished), .wdata({store[cur_waddr], cur_tag}),
    .pop(out_pop), .rdata(oq_rdata), .full(out_full), .empty(out_empty)
  );

  assign out_data = oq_rdata[OQ_W-1 -: DATA_W];
  assign out_tag  = oq_rdata[TAG_W-1:0];

endmodule

// File: rtl/bank_rr_arb.sv
module bank_rr_arb #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  import bank_pkg::*;
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [IDX_W-1:0] last;
  int unsigned      pick;

  always_comb begin
    pick = rr_next(64'(req), int'(last), N);
    for (int i = 0; i < N; i++) grant[i] = (pick == i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    last <= IDX_W'(N - 1);
    else if (|req) last <= IDX_W'(pick);
  end

endmodule

// File: rtl/bank_array.sv
module bank_array #(
  parameter int N_MOD    = 16,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int TAG_W    = 6,
  parameter int CYCLE    = 12,
  parameter int ACCESS   = 8,
  parameter int IQ_DEPTH = 8,
  parameter int OQ_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [TAG_W-1:0]  rsp_tag
);
  localparam int MOD_W  = $clog2(N_MOD);
  localparam int WORD_W = ADDR_W - MOD_W;

  logic [MOD_W-1:0]  target;
  logic              accept;
  logic [N_MOD-1:0]  iq_push_v, iq_full_v;
  logic [N_MOD-1:0]  oq_empty_v, oq_full_v, oq_push_v;
  logic [N_MOD-1:0]  start_v, grant_v;
  logic [DATA_W-1:0] out_data_a [N_MOD];
  logic [TAG_W-1:0]  out_tag_a  [N_MOD];
  logic [DATA_W-1:0] sel_data;
  logic [TAG_W-1:0]  sel_tag;

  assign target    = req_addr[MOD_W-1:0];
  assign req_ready = !iq_full_v[target];
  assign accept    = req_valid && req_ready;

  for (genvar g = 0; g < N_MOD; g++) begin : g_mod
    assign iq_push_v[g] = accept && (target == MOD_W'(g));

    bank_module #(
      .WORD_W(WORD_W), .DATA_W(DATA_W), .TAG_W(TAG_W),
      .CYCLE(CYCLE), .ACCESS(ACCESS),
      .IQ_DEPTH(IQ_DEPTH), .OQ_DEPTH(OQ_DEPTH)
    ) u_mod (
      .clk(clk), .rst_n(rst_n),
      .in_push(iq_push_v[g]), .in_write(req_write),
      .in_waddr(req_addr[ADDR_W-1:MOD_W]), .in_wdata(req_wdata),
      .in_tag(req_tag), .in_full(iq_full_v[g]),
      .out_pop(grant_v[g]), .out_data(out_data_a[g]), .out_tag(out_tag_a[g]),
      .out_empty(oq_empty_v[g]), .out_full(oq_full_v[g]),
      .started(start_v[g]), .finished(oq_push_v[g])
    );
  end

  bank_rr_arb #(.N(N_MOD)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(~oq_empty_v), .grant(grant_v)
  );

  always_comb begin
    sel_data = '0;
    sel_tag  = '0;
    for (int i = 0; i < N_MOD; i++) begin
      if (grant_v[i]) begin
        sel_data = out_data_a[i];
        sel_tag  = out_tag_a[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_tag   <= '0;
    end else begin
      rsp_valid <= |grant_v;
      rsp_data  <= sel_data;
      rsp_tag   <= sel_tag;
    end
  end

endmodule

// File: rtl/bank_array_chk.sv
module bank_array_chk #(
  parameter int N_MOD = 16,
  parameter int CYCLE = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_MOD-1:0] iq_push,
  input logic [N_MOD-1:0] iq_full,
  input logic [N_MOD-1:0] oq_push,
  input logic [N_MOD-1:0] oq_full,
  input logic [N_MOD-1:0] mod_start,
  input logic [N_MOD-1:0] grant,
  input logic             rsp_valid
);
  localparam int SW = $clog2(CYCLE + 1);

  AST_NO_IQ_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (iq_push & iq_full) == '0);  // R2
  AST_NO_OQ_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (oq_push & oq_full) == '0);  // R8
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));  // R7
  AST_GRANT_REACHES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |=> rsp_valid);  // R7

  for (genvar g = 0; g < N_MOD; g++) begin : g_gap
    logic [SW-1:0] since;
    always_ff @(posedge clk) begin
      if (!rst_n)            since <= SW'(CYCLE);
      else if (mod_start[g]) since <= SW'(1);
      else if (since != SW'(CYCLE)) since <= since + 1'b1;
    end
    AST_START_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      mod_start[g] |-> (since == SW'(CYCLE)));  // R4
  end

endmodule

bind bank_array bank_array_chk #(.N_MOD(N_MOD), .CYCLE(CYCLE)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .iq_push(iq_push_v), .iq_full(iq_full_v),
  .oq_push(oq_push_v), .oq_full(oq_full_v),
  .mod_start(start_v), .grant(grant_v), .rsp_valid(rsp_valid)
);

// File: tb/bank_array_bench.sv
`timescale 1ns/1ps
module bank_array_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [5:0]  req_tag = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_data;
  logic [5:0]  rsp_tag;

  int n_chk = 0, n_fail = 0;
  bit finished_run = 0;
  logic [15:0] exp_data [64];
  bit          exp_pend [64];

  always #5 clk = ~clk;

  bank_array u_bank_array (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_tag(req_tag),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_tag(rsp_tag)
  );

  // rows: {write, addr, data (expected data for reads), tag}
  localparam logic [30:0] VEC [12] = '{
    {1'b1, 8'h10, 16'h1111, 6'd0},
    {1'b1, 8'h21, 16'h2222, 6'd0},
    {1'b1, 8'h32, 16'h3333, 6'd0},
    {1'b1, 8'h10, 16'h4444, 6'd0},
    {1'b0, 8'h10, 16'h4444, 6'd1},
    {1'b0, 8'h21, 16'h2222, 6'd2},
    {1'b0, 8'h32, 16'h3333, 6'd3},
    {1'b1, 8'h21, 16'h5555, 6'd0},
    {1'b0, 8'h21, 16'h5555, 6'd4},
    {1'b1, 8'h4F, 16'h6666, 6'd0},
    {1'b0, 8'h4F, 16'h6666, 6'd5},
    {1'b0, 8'h10, 16'h4444, 6'd6}
  };

  task automatic check(bit ok, string rq, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the accepting edge
  task automatic issue(bit w, logic [7:0] a, logic [15:0] d, logic [5:0] t, output int stalls);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_tag = t;
    if (!w) begin exp_data[t] = d; exp_pend[t] = 1'b1; end
    stalls = 0;
    while (!req_ready) begin @(negedge clk); stalls++; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp(output int lat, output logic [5:0] tag);
    lat = 0;
    do begin @(negedge clk); lat++; end while (!rsp_valid && lat < 200);
    tag = rsp_tag;
  endtask

  // every returned result must match the pending read with its tag (R5, R10)
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      check(exp_pend[rsp_tag] && rsp_data == exp_data[rsp_tag], "R5",
            "returned data", rsp_data, exp_data[rsp_tag]);
      exp_pend[rsp_tag] = 1'b0;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished_run) begin
      n_chk++; n_fail++;
      $display("FAIL R7 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int s, lat, lat2, pend;
    logic [5:0] t1, t2;
    for (int i = 0; i < 64; i++) exp_pend[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    check(rsp_valid == 1'b0, "R9", "rsp_valid after reset", rsp_valid, 0);
    for (int m = 0; m < 16; m++) begin
      req_addr = 8'(m);
      #1;
      check(req_ready == 1'b1, "R9", "req_ready after reset", req_ready, 1);
    end
    @(negedge clk);

    // table walk: R1, R5, R10
    for (int i = 0; i < 12; i++) begin
      issue(VEC[i][30], VEC[i][29:22], VEC[i][21:6], VEC[i][5:0], s);
      check(s == 0, "R1", "table row stall", s, 0);
    end
    repeat (200) @(negedge clk);

    // setup writes for directed tests
    issue(1, 8'h25, 16'hAAAA, 0, s);
    issue(1, 8'h35, 16'hBBBB, 0, s);
    issue(1, 8'h58, 16'hC0DE, 0, s);
    issue(1, 8'h73, 16'h7373, 0, s);
    repeat (60) @(negedge clk);

    // R3: single read latency
    issue(0, 8'h25, 16'hAAAA, 6'd10, s);
    wait_rsp(lat, t1);
    check(lat == 10 && t1 == 6'd10, "R3", "idle read latency", lat, 10);
    repeat (20) @(negedge clk);

    // R4: back-to-back reads to one module
    issue(0, 8'h25, 16'hAAAA, 6'd11, s);
    issue(0, 8'h35, 16'hBBBB, 6'd12, s);
    wait_rsp(lat, t1);
    wait_rsp(lat2, t2);
    check(lat == 9 && t1 == 6'd11, "R4", "first read return", lat, 9);
    check(lat2 == 12 && t2 == 6'd12, "R4", "second read spacing", lat2, 12);
    repeat (20) @(negedge clk);

    // R6: out-of-order return
    issue(1, 8'h47, 16'h4747, 0, s);
    issue(0, 8'h47, 16'h4747, 6'd13, s);
    issue(0, 8'h58, 16'hC0DE, 6'd14, s);
    wait_rsp(lat, t1);
    wait_rsp(lat2, t2);
    check(t1 == 6'd14 && lat == 10, "R6", "later read returns first", t1, 14);
    check(t2 == 6'd13 && lat2 == 10, "R6", "busy-module read returns second", t2, 13);
    repeat (20) @(negedge clk);

    // R7: two completions in the same cycle
    issue(1, 8'h62, 16'h6262, 0, s);
    issue(0, 8'h62, 16'h6262, 6'd15, s);
    repeat (10) @(negedge clk);
    issue(0, 8'h73, 16'h7373, 6'd16, s);
    wait_rsp(lat, t1);
    wait_rsp(lat2, t2);
    check(lat == 10, "R7", "first of colliding results", lat, 10);
    check(lat2 == 1, "R7", "second result on next cycle", lat2, 1);
    check((t1 == 6'd15 && t2 == 6'd16) || (t1 == 6'd16 && t2 == 6'd15),
          "R7", "both tags delivered", {t1, t2}, {6'd15, 6'd16});
    repeat (20) @(negedge clk);

    // R2: input queue full stalls the requester
    lat = 0;
    for (int k = 0; k < 9; k++) begin
      issue(1, 8'((k << 4) | 9), 16'(16'h9000 + k), 0, s);
      lat += s;
    end
    check(lat == 0, "R2", "stalls over nine writes", lat, 0);
    issue(1, 8'h99, 16'h9999, 0, s);
    check(s == 5, "R2", "stall cycles of tenth write", s, 5);
    issue(0, 8'h99, 16'h9999, 6'd17, s);
    issue(0, 8'h89, 16'h9008, 6'd18, s);

    // R8/R7: everything drains
    repeat (400) @(negedge clk);
    pend = 0;
    for (int i = 0; i < 64; i++) if (exp_pend[i]) pend++;
    check(pend == 0, "R8", "reads still outstanding", pend, 0);

    finished_run = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule